// File: doc/BRIEF.md
# Single-Wire Bus Bit Master

This block issues single bit-level operations on a single-wire open-drain bus. There are three operations: a bus reset with a presence check, a one-bit write slot, and a one-bit read slot. A client puts an operation code on `cmd` and pulses `start`. The block raises `busy` while the operation runs. When it finishes, it pulses `done` for one cycle, and `result` holds the presence flag or the bit that was read. Building bytes, searching device identities and checking CRCs are left to the logic above this block.

All durations are counted in microsecond ticks. A divider derives the tick from the system clock using `CLK_FREQ`, and the divider restarts each time an operation is accepted, so one microsecond is always exactly `CLK_FREQ/1e6` cycles.

The pad is driven through `bus_oe` and `bus_out`, which gives three line states: pulled low, released, or driven high. Driving the line high between operations supplies parasitically powered devices. The returned line `bus_in` passes through a two-flop synchroniser before it is sampled. The line is never sampled continuously: it is polled at 5 µs steps inside a bounded window.

Top module: `onewire_master`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done` and `result` are 0, and the line is driven high (`bus_oe`=1, `bus_out`=1).
- R2: `cmd`=0 selects a bus reset. From the accepting edge, the line is pulled low (`bus_oe`=1, `bus_out`=0) for exactly 500 µs and is then released (`bus_oe`=0).
- R3: After the reset release, the line is polled at 5, 10, …, 240 µs. A low at any poll ends the window and gives `result`=1. No low up to 240 µs, including a low that starts only after 240 µs, gives `result`=0.
- R4: When the presence window ends, the line stays released for a further 450 µs before `done`. A reset with no device therefore takes exactly 1190 µs from accept to `done`.
- R5: `cmd`=1 is a write of `wbit`. A one pulls the line low for 2 µs and a zero pulls it low for 62 µs. The line is then driven high until the 64 µs slot ends. `result` echoes the written bit.
- R6: `cmd`=2 or 3 is a read. The line is pulled low for 2 µs and then released, and polled at 7, 12, …, 42 µs from slot start. A low at a poll gives `result`=0, otherwise `result`=1. The slot lasts 64 µs.
- R7: Once any operation completes, the line is driven high (`bus_oe`=1, `bus_out`=1) for as long as the block is idle.
- R8: `done` is high for exactly one cycle. In that cycle `busy` is already 0 and `result` is valid. `result` then holds until the next `done`.
- R9: `start` is ignored while `busy` is high. The running operation keeps its timing and raises `done` once.
- R10: Raising `rst` in the middle of an operation returns the block to idle in the next cycle, with the line driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation (taken only when idle) |
| cmd | input | 2 | 0 bus reset, 1 write, 2 or 3 read |
| wbit | input | 1 | Bit value for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Presence flag, read bit, or echoed write bit |
| bus_oe | output | 1 | Pad output enable (0 releases the line) |
| bus_out | output | 1 | Pad output value when enabled |
| bus_in | input | 1 | Line level, asynchronous |

## Verification
Any error in the phase counter shows up directly as a wrong length of the low pulse or of the whole busy window. These lengths are counted in cycles at the ports, and the error is visible within the same operation. An error in the poll counter or the window limit moves the poll points. This shows up as a flipped `result` when the device's low pulse is placed just inside or just outside a window edge (42 µs in a read, 240 µs in a reset). A stuck phase state leaves `busy` high with no `done`, and the bench's cycle limit catches that.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_POLL,
        ST_RST_REC,
        ST_SLOT_LOW,
        ST_SLOT_HIGH,
        ST_RD_POLL,
        ST_RD_PAD
    } owm_state_e;

    localparam logic [1:0] CMD_BUSRST = 2'd0;
    localparam logic [1:0] CMD_WRITE  = 2'd1;

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == CW'(DIV - 1));
        if (restart || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int RST_LOW_US  = 500,
    parameter int PRES_WIN_US = 240,
    parameter int RST_REC_US  = 450,
    parameter int POLL_US     = 5,
    parameter int SLOT_US     = 64,
    parameter int SHORT_US    = 2,
    parameter int LONG_US     = 62,
    parameter int READ_WIN_US = 45,
    parameter int EW          = 10,
    parameter int PW          = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic       start,
    input  logic [1:0] cmd,
    input  logic       wbit,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       oe,
    output logic       out
);
    typedef struct packed {
        owm_state_e    st;
        logic [EW-1:0] el;
        logic [PW-1:0] pc;
        logic          rd;
        logic          wb;
        logic          samp;
        logic          res;
        logic          done;
        logic          oe;
        logic          out;
    } seq_t;

    seq_t          r_d, r_q;
    logic [EW-1:0] el_inc;
    logic [EW-1:0] low_end;
    logic          poll;
    logic          fin;
    logic          fin_val;

    always_comb begin
        el_inc  = r_q.el + 1'b1;
        low_end = (r_q.rd || r_q.wb) ? EW'(SHORT_US) : EW'(LONG_US);
        poll    = tick && (r_q.pc == PW'(POLL_US - 1));
        r_d      = r_q;
        r_d.done = 1'b0;
        accept   = 1'b0;
        fin      = 1'b0;
        fin_val  = r_q.samp;
        if (tick && r_q.st != ST_IDLE) begin
            r_d.el = el_inc;
            r_d.pc = poll ? '0 : r_q.pc + 1'b1;
        end
        case (r_q.st)
            ST_IDLE: if (start) begin
                accept  = 1'b1;
                r_d.el  = '0;
                r_d.pc  = '0;
                r_d.oe  = 1'b1;
                r_d.out = 1'b0;
                r_d.rd  = cmd[1];
                r_d.wb  = wbit;
                r_d.st  = (cmd == CMD_BUSRST) ? ST_RST_LOW : ST_SLOT_LOW;
            end
            ST_RST_LOW: if (tick && el_inc == EW'(RST_LOW_US)) begin
                r_d.st = ST_RST_POLL;
                r_d.el = '0;
                r_d.pc = '0;
                r_d.oe = 1'b0;
            end
            ST_RST_POLL: if (poll) begin
                if (!line) begin
                    r_d.samp = 1'b1;
                    r_d.st   = ST_RST_REC;
                    r_d.el   = '0;
                end else if (int'(el_inc) + POLL_US > PRES_WIN_US) begin
                    r_d.samp = 1'b0;
                    r_d.st   = ST_RST_REC;
                    r_d.el   = '0;
                end
            end
            ST_RST_REC: if (tick && el_inc == EW'(RST_REC_US)) fin = 1'b1;
            ST_SLOT_LOW: if (tick && el_inc == low_end) begin
                if (r_q.rd) begin
                    r_d.st = ST_RD_POLL;
                    r_d.oe = 1'b0;
                    r_d.pc = '0;
                end else begin
                    r_d.st  = ST_SLOT_HIGH;
                    r_d.out = 1'b1;
                end
            end
            ST_SLOT_HIGH: if (tick && el_inc == EW'(SLOT_US)) begin
                fin     = 1'b1;
                fin_val = r_q.wb;
            end
            ST_RD_POLL: if (poll) begin
                if (!line) begin
                    r_d.samp = 1'b0;
                    r_d.st   = ST_RD_PAD;
                end else if (int'(el_inc) + POLL_US > READ_WIN_US) begin
                    r_d.samp = 1'b1;
                    r_d.st   = ST_RD_PAD;
                end
            end
            ST_RD_PAD: if (tick && el_inc == EW'(SLOT_US)) fin = 1'b1;
            default: r_d.st = ST_IDLE;
        endcase
        if (fin) begin
            r_d.st   = ST_IDLE;
            r_d.oe   = 1'b1;
            r_d.out  = 1'b1;
            r_d.done = 1'b1;
            r_d.res  = fin_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '0;
            r_q.oe  <= 1'b1;
            r_q.out <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = r_q.done;
    assign result = r_q.res;
    assign oe     = r_q.oe;
    assign out    = r_q.out;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.done |=> !r_q.done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.done |-> (r_q.st == ST_IDLE));
    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE) |-> (r_q.oe && r_q.out));
    // R6
    poll_released_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_RD_POLL || r_q.st == ST_RST_POLL) |-> !r_q.oe);
    // R9
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_RST_LOW) |=> (r_q.st == ST_RST_LOW || r_q.st == ST_RST_POLL));
    // R9
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_SLOT_HIGH) |=> (r_q.st == ST_SLOT_HIGH || r_q.st == ST_IDLE));
endmodule

// File: rtl/onewire_master.sv
module onewire_master #(
    parameter int CLK_FREQ    = 50_000_000,
    parameter int RST_LOW_US  = 500,
    parameter int PRES_WIN_US = 240,
    parameter int RST_REC_US  = 450,
    parameter int POLL_US     = 5,
    parameter int SLOT_US     = 64,
    parameter int SHORT_US    = 2,
    parameter int LONG_US     = 62,
    parameter int READ_WIN_US = 45
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] cmd,
    input  logic       wbit,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       bus_oe,
    output logic       bus_out,
    input  logic       bus_in
);
    localparam int DIV    = (CLK_FREQ / 1_000_000 > 1) ? CLK_FREQ / 1_000_000 : 1;
    localparam int MAX_A  = (RST_LOW_US > RST_REC_US) ? RST_LOW_US : RST_REC_US;
    localparam int MAX_B  = (PRES_WIN_US > SLOT_US) ? PRES_WIN_US : SLOT_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int EW     = $clog2(MAX_US + POLL_US + 1);
    localparam int PW     = (POLL_US > 1) ? $clog2(POLL_US) : 1;

    logic tick;
    logic accept;
    logic line_s;

    owm_tick #(.DIV(DIV)) i_tick (
        .clk(clk), .rst(rst), .restart(accept), .tick(tick)
    );

    owm_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .din(bus_in), .dout(line_s)
    );

    owm_seq #(
        .RST_LOW_US(RST_LOW_US), .PRES_WIN_US(PRES_WIN_US), .RST_REC_US(RST_REC_US),
        .POLL_US(POLL_US), .SLOT_US(SLOT_US), .SHORT_US(SHORT_US), .LONG_US(LONG_US),
        .READ_WIN_US(READ_WIN_US), .EW(EW), .PW(PW)
    ) i_seq (
        .clk(clk), .rst(rst), .tick(tick), .line(line_s), .start(start), .cmd(cmd),
        .wbit(wbit), .accept(accept), .busy(busy), .done(done), .result(result),
        .oe(bus_oe), .out(bus_out)
    );
endmodule

// File: tb/test_onewire_master.sv
module test_onewire_master;
    localparam int D  = 4;
    localparam int NV = 11;
    // entry: cmd[47:46] wbit[45] dev_start[44:36] dev_len[35:27] exp[26] low_us[25:16] busy_us[15:0]
    localparam logic [47:0] VEC [NV] = '{
        {2'd1, 1'b1, 9'd0,   9'd0,   1'b1, 10'd2,   16'd64},
        {2'd1, 1'b0, 9'd0,   9'd0,   1'b0, 10'd62,  16'd64},
        {2'd2, 1'b0, 9'd0,   9'd0,   1'b1, 10'd2,   16'd64},
        {2'd2, 1'b0, 9'd3,   9'd15,  1'b0, 10'd2,   16'd64},
        {2'd2, 1'b0, 9'd37,  9'd5,   1'b0, 10'd2,   16'd64},
        {2'd2, 1'b1, 9'd41,  9'd10,  1'b1, 10'd2,   16'd64},
        {2'd3, 1'b0, 9'd3,   9'd15,  1'b0, 10'd2,   16'd64},
        {2'd0, 1'b0, 9'd0,   9'd0,   1'b0, 10'd500, 16'd1190},
        {2'd0, 1'b0, 9'd32,  9'd120, 1'b1, 10'd500, 16'd985},
        {2'd0, 1'b0, 9'd236, 9'd20,  1'b1, 10'd500, 16'd1190},
        {2'd0, 1'b0, 9'd242, 9'd40,  1'b0, 10'd500, 16'd1190}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic wbit = 1'b0;
    logic busy, done, result, bus_oe, bus_out, bus_in;
    logic dev_low;
    int rel_cnt = 0;
    int dev_start = 0;
    int dev_len = 0;
    int n_cmp = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    onewire_master #(.CLK_FREQ(D * 1_000_000)) i_onewire_master (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .wbit(wbit),
        .busy(busy), .done(done), .result(result),
        .bus_oe(bus_oe), .bus_out(bus_out), .bus_in(bus_in)
    );

    always @(posedge clk) rel_cnt <= bus_oe ? 0 : rel_cnt + 1;
    always_comb dev_low = !bus_oe && dev_len > 0 && rel_cnt >= dev_start * D
                          && rel_cnt < (dev_start + dev_len) * D;
    assign bus_in = (bus_oe && !bus_out) ? 1'b0 : !dev_low;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] c, input logic b, input int poke,
                           output int lowc, output int busyc, output int res, output int donec);
        @(negedge clk);
        cmd = c; wbit = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lowc = 0; busyc = 0; donec = 0;
        while (!done) begin
            if (busy) busyc++;
            if (bus_oe && !bus_out) lowc++;
            start = (poke > 0 && busyc == poke);
            if (start) cmd = 2'd0;
            @(negedge clk);
        end
        start = 1'b0;
        res = result;
        donec = 1;
        chk("R8 busy at done", busy, 0);
        @(negedge clk);
        if (done) donec++;
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        n_cmp++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        int lowc, busyc, res, donec;
        string rq;
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        chk("R1 busy", busy, 0);
        chk("R1 line oe", bus_oe, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
        chk("R1 line out", bus_out, 1);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            dev_start = int'(v[44:36]);
            dev_len   = int'(v[35:27]);
            run_cmd(v[47:46], v[45], 0, lowc, busyc, res, donec);
            rq = (v[47:46] == 2'd0) ? "R3" : (v[47:46] == 2'd1) ? "R5" : "R6";
            chk(rq, res, int'(v[26]));
            rq = (v[47:46] == 2'd0) ? "R2 low" : (v[47:46] == 2'd1) ? "R5 low" : "R6 low";
            chk(rq, lowc, int'(v[25:16]) * D);
            rq = (v[47:46] == 2'd0) ? "R4 length" : (v[47:46] == 2'd1) ? "R5 length" : "R6 length";
            chk(rq, busyc, int'(v[15:0]) * D);
            chk("R8 done width", donec, 1);
            chk("R7 idle line", {30'd0, bus_oe, bus_out}, 3);
            dev_len = 0;
        end

        // R8 result held after done
        repeat (20) @(negedge clk);
        chk("R8 result held", result, 0);

        // R9 start while busy ignored
        run_cmd(2'd1, 1'b0, 30 * D, lowc, busyc, res, donec);
        chk("R9 low", lowc, 62 * D);
        chk("R9 length", busyc, 64 * D);
        chk("R9 done count", donec, 1);
        repeat (10) @(negedge clk);
        chk("R9 stays idle", busy, 0);

        // R10 reset in the middle of a bus reset
        @(negedge clk);
        cmd = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        chk("R10 low before", {31'd0, bus_oe && !bus_out}, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 busy", busy, 0);
        chk("R10 line", {30'd0, bus_oe, bus_out}, 3);
        rst = 1'b0;
        run_cmd(2'd1, 1'b1, 0, lowc, busyc, res, donec);
        chk("R10 next op", res, 1);
        chk("R10 next low", lowc, 2 * D);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule